// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block holds wall-clock time and calendar date as packed BCD fields: seconds, minutes, hours, day of month, month, two-digit year and a three-bit weekday. A one-cycle advance strobe, normally produced once per second by an external prescaler, moves the time forward by one second. Carries then run through every field, honouring month lengths and a leap rule applied to the two-digit year. Hours run in either a 24-hour or a 12-hour form, selected by a bit inside the hour field itself.

Software-side logic sets the time through a narrow write port: a field index, a data byte, a strobe and a permission input that stands for the write-enable control bit. After reset the block treats itself as having lost all power. It raises a loss flag and will not count until the first accepted write. A halt request freezes counting until the next accepted write. Each accepted write also emits a one-cycle pulse so that the external one-second divider can restart its phase.

Top module: `tcal_counter`

## Requirements
- R1: After reset the fields read seconds 00, minutes 00, hour 8'h12 (12-hour form, AM), date 01, month 01, year 00, weekday 0, with `pwr_lost_o` = 1 and `resync_o` = 0.
- R2: While `pwr_lost_o` is 1, advance strobes change no field. The first accepted write clears `pwr_lost_o`, and later strobes advance the time.
- R3: A write is accepted only when `wr_en` and `wr_allow` are both 1 and `wr_idx` is 0 to 6 (0 seconds, 1 minutes, 2 hour, 3 date, 4 month, 5 year, 6 weekday). Index 7, or `wr_allow` = 0, changes no field and leaves `pwr_lost_o` unchanged.
- R4: Seconds and minutes count in BCD from 00 to 59. Each passes a carry to the next field on the step from 59 to 00.
- R5: With hour bit 7 = 1 (24-hour form), bits 5:0 count BCD 00 to 23, and the step from 23 to 00 carries into the date.
- R6: With hour bit 7 = 0 (12-hour form), bits 4:0 run 12, 01, ..., 11 and bit 5 is the PM flag (1 = PM). The flag flips on the step from 11 to 12. The step from 11 PM to 12 AM carries into the date.
- R7: The date restarts at 01 after day 30 in months 04, 06, 09 and 11, and after day 31 in the other months except February. The month runs 01 to 12 and then restarts at 01, carrying into the year. The year wraps from 99 to 00.
- R8: February ends after day 29 when the year value is divisible by 4 (including 00), and after day 28 otherwise.
- R9: The weekday advances by one on every date carry and wraps from 6 to 0.
- R10: A pulse on `halt_req` freezes all fields against later strobes. Any accepted write releases the freeze.
- R11: In a cycle with both an accepted write and an advance strobe, the written field takes the data and no other field moves.
- R12: `resync_o` is 1 for exactly the one cycle that follows each accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; models return from total power loss |
| tick_i | input | 1 | One-second advance strobe |
| halt_req | input | 1 | Pulse that freezes counting |
| wr_en | input | 1 | Write strobe |
| wr_allow | input | 1 | Write permission |
| wr_idx | input | 3 | Field index |
| wr_data | input | 8 | Field value, BCD |
| sec_o | output | 8 | Seconds |
| min_o | output | 8 | Minutes |
| hour_o | output | 8 | Hour; bit 7 form, bit 5 PM in 12-hour form |
| date_o | output | 8 | Day of month |
| month_o | output | 8 | Month |
| year_o | output | 8 | Year |
| wday_o | output | 8 | Weekday, 0 to 6 |
| pwr_lost_o | output | 1 | Total power loss flag |
| resync_o | output | 1 | One-second phase restart pulse |

## Verification
Every result is registered once. A write or advance strobe presented before a rising edge shows on the outputs after that edge, and the full carry chain from seconds to year settles within that same edge. `resync_o` and the clearing of `pwr_lost_o` also appear one edge after the accepted write. The bench drives inputs on falling edges and samples on the falling edge that follows the active rising edge, so each expected value is compared exactly one cycle after its cause. The freeze checks sample again after several strobes.

// File: rtl/tcal_pkg.sv
package tcal_pkg;

  localparam int BYTE_W = 8;

  // BCD increment of a two-digit byte
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [6:0] bcd_val(input logic [7:0] v);
    return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
  endfunction

  // last valid date (BCD) of a month; leap rule on the two-digit year only
  function automatic logic [5:0] month_last(input logic [4:0] mon, input logic [7:0] yr);
    logic [6:0] y;
    y = bcd_val(yr);
    case (mon)
      5'h02:                      return (y[1:0] == 2'b00) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction

endpackage

// File: rtl/tcal_wrapctr.sv
module tcal_wrapctr #(
  parameter int W = 7,
  parameter logic [W-1:0] FIRST = '0,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic [W-1:0] last_i,
  output logic [W-1:0] val_o,
  output logic         at_last_o
);
  logic [W-1:0] val_q;
  logic [7:0]   inc8;

  assign inc8      = tcal_pkg::bcd_inc(8'(val_q));
  assign at_last_o = (val_q >= last_i);
  assign val_o     = val_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      val_q <= RST;
    else if (ld)     val_q <= ld_val;
    else if (adv)    val_q <= at_last_o ? FIRST : inc8[W-1:0];
  end

  // R4 (also R7, R9): a field at its end value restarts at its first value
  a_r4_wrap_to_first: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !ld && at_last_o) |=> (val_q == FIRST));

  a_r4_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !ld && !at_last_o) |=> (val_q != $past(val_q)));

endmodule

// File: rtl/tcal_hour.sv
module tcal_hour (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adv,
  input  logic       ld,
  input  logic [7:0] ld_val,
  output logic [7:0] hour_o,
  output logic       day_o
);
  localparam logic [7:0] HOUR_RST = 8'h12;
  localparam logic [7:0] LD_MASK  = 8'hBF;

  logic [7:0] hr_q, nxt, inc24, inc12;
  logic       mode24, pm, day_raw;
  logic [5:0] h24;
  logic [4:0] h12;

  assign mode24 = hr_q[7];
  assign pm     = hr_q[5];
  assign h24    = hr_q[5:0];
  assign h12    = hr_q[4:0];
  assign inc24  = tcal_pkg::bcd_inc({2'b00, h24});
  assign inc12  = tcal_pkg::bcd_inc({3'b000, h12});

  always_comb begin
    nxt     = hr_q;
    day_raw = 1'b0;
    if (mode24) begin
      if (h24 >= 6'h23) begin
        nxt     = 8'h80;
        day_raw = 1'b1;
      end else begin
        nxt = {2'b10, inc24[5:0]};
      end
    end else begin
      if (h12 == 5'h11) begin
        nxt     = {2'b00, ~pm, 5'h12};
        day_raw = pm;
      end else if (h12 >= 5'h12) begin
        nxt = {2'b00, pm, 5'h01};
      end else begin
        nxt = {2'b00, pm, inc12[4:0]};
      end
    end
  end

  assign day_o  = adv && day_raw;
  assign hour_o = hr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   hr_q <= HOUR_RST;
    else if (ld)  hr_q <= ld_val & LD_MASK;
    else if (adv) hr_q <= nxt;
  end

  // R6: PM flag flips when 11 becomes 12
  a_r6_pm_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !ld && !hr_q[7] && hr_q[4:0] == 5'h11) |=> (hr_q[5] != $past(hr_q[5])));

  // R5: 24-hour form wraps 23 to 00
  a_r5_midnight: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !ld && hr_q[7] && hr_q[5:0] == 6'h23) |=> (hr_q == 8'h80));

endmodule

// File: rtl/tcal_counter.sv
module tcal_counter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       halt_req,
  input  logic       wr_en,
  input  logic       wr_allow,
  input  logic [2:0] wr_idx,
  input  logic [7:0] wr_data,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] date_o,
  output logic [7:0] month_o,
  output logic [7:0] year_o,
  output logic [7:0] wday_o,
  output logic       pwr_lost_o,
  output logic       resync_o
);
  localparam int NFIELD = 7;
  localparam int SEC_W  = 7;
  localparam int DATE_W = 6;
  localparam int MON_W  = 5;
  localparam int YR_W   = 8;
  localparam int WDAY_W = 3;

  logic              acc_wr, fail_q, halt_q, resync_q;
  logic [NFIELD-1:0] ld_w;
  logic              adv_sec, adv_min, adv_hr, adv_day, adv_mon, adv_yr;
  logic              sec_last, min_last, date_last, mon_last, yr_last, wday_last;
  logic [SEC_W-1:0]  sec_w, min_w;
  logic [7:0]        hour_w;
  logic [DATE_W-1:0] date_w, date_end;
  logic [MON_W-1:0]  mon_w;
  logic [YR_W-1:0]   yr_w;
  logic [WDAY_W-1:0] wday_w;

  assign acc_wr = wr_en && wr_allow && (wr_idx != 3'd7);

  generate
    for (genvar g = 0; g < NFIELD; g++) begin : g_ld
      assign ld_w[g] = acc_wr && (wr_idx == 3'(g));
    end
  endgenerate

  // carry chain
  assign adv_sec = tick_i && !fail_q && !halt_q && !acc_wr;
  assign adv_min = adv_sec && sec_last;
  assign adv_hr  = adv_min && min_last;
  assign adv_mon = adv_day && date_last;
  assign adv_yr  = adv_mon && mon_last;
  assign date_end = tcal_pkg::month_last(mon_w, yr_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_q   <= 1'b1;
      halt_q   <= 1'b0;
      resync_q <= 1'b0;
    end else begin
      resync_q <= acc_wr;
      if (acc_wr) begin
        fail_q <= 1'b0;
        halt_q <= 1'b0;
      end else if (halt_req) begin
        halt_q <= 1'b1;
      end
    end
  end

  tcal_wrapctr #(.W(SEC_W)) u_sec (
    .clk, .rst_n, .adv(adv_sec), .ld(ld_w[0]), .ld_val(wr_data[SEC_W-1:0]),
    .last_i(7'h59), .val_o(sec_w), .at_last_o(sec_last));

  tcal_wrapctr #(.W(SEC_W)) u_min (
    .clk, .rst_n, .adv(adv_min), .ld(ld_w[1]), .ld_val(wr_data[SEC_W-1:0]),
    .last_i(7'h59), .val_o(min_w), .at_last_o(min_last));

  tcal_hour u_hour (
    .clk, .rst_n, .adv(adv_hr), .ld(ld_w[2]), .ld_val(wr_data),
    .hour_o(hour_w), .day_o(adv_day));

  tcal_wrapctr #(.W(DATE_W), .FIRST(6'h01), .RST(6'h01)) u_date (
    .clk, .rst_n, .adv(adv_day), .ld(ld_w[3]), .ld_val(wr_data[DATE_W-1:0]),
    .last_i(date_end), .val_o(date_w), .at_last_o(date_last));

  tcal_wrapctr #(.W(MON_W), .FIRST(5'h01), .RST(5'h01)) u_mon (
    .clk, .rst_n, .adv(adv_mon), .ld(ld_w[4]), .ld_val(wr_data[MON_W-1:0]),
    .last_i(5'h12), .val_o(mon_w), .at_last_o(mon_last));

  tcal_wrapctr #(.W(YR_W)) u_yr (
    .clk, .rst_n, .adv(adv_yr), .ld(ld_w[5]), .ld_val(wr_data[YR_W-1:0]),
    .last_i(8'h99), .val_o(yr_w), .at_last_o(yr_last));

  tcal_wrapctr #(.W(WDAY_W)) u_wday (
    .clk, .rst_n, .adv(adv_day), .ld(ld_w[6]), .ld_val(wr_data[WDAY_W-1:0]),
    .last_i(3'd6), .val_o(wday_w), .at_last_o(wday_last));

  assign sec_o      = 8'(sec_w);
  assign min_o      = 8'(min_w);
  assign hour_o     = hour_w;
  assign date_o     = 8'(date_w);
  assign month_o    = 8'(mon_w);
  assign year_o     = yr_w;
  assign wday_o     = 8'(wday_w);
  assign pwr_lost_o = fail_q;
  assign resync_o   = resync_q;

  // R2: frozen while the loss flag is up and nothing is written
  a_r2_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_q && !acc_wr) |=> $stable({sec_w, min_w, hour_w, date_w, mon_w, yr_w, wday_w}));

  // R2: an accepted write clears the loss flag
  a_r2_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    acc_wr |=> !pwr_lost_o);

  // R10: halted time stays put
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_q && !acc_wr) |=> $stable({sec_w, min_w, hour_w, date_w, mon_w, yr_w, wday_w}));

  // R11: a write to another field leaves seconds alone
  a_r11_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && wr_idx != 3'd0) |=> $stable(sec_w));

  // R12: resync pulse follows each accepted write
  a_r12_resync: assert property (@(posedge clk) disable iff (!rst_n)
    acc_wr |=> resync_o);

  // R9: weekday wraps with the date carry
  a_r9_wday_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_day && !acc_wr && wday_w == 3'd6) |=> (wday_w == 3'd0));

  // R7: year wraps 99 to 00 on a month carry from December
  a_r7_year_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_yr && yr_last) |=> (yr_w == 8'h00));

endmodule

// File: tb/tcal_counter_bench.sv
`timescale 1ns/1ps
module tcal_counter_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_i = 1'b0, halt_req = 1'b0, wr_en = 1'b0, wr_allow = 1'b1;
  logic [2:0] wr_idx = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] sec_o, min_o, hour_o, date_o, month_o, year_o, wday_o;
  logic pwr_lost_o, resync_o;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tcal_counter u_tcal_counter (
    .clk, .rst_n, .tick_i, .halt_req, .wr_en, .wr_allow, .wr_idx, .wr_data,
    .sec_o, .min_o, .hour_o, .date_o, .month_o, .year_o, .wday_o,
    .pwr_lost_o, .resync_o);

  // start fields (sec,min,hour,date,month,year,wday) then expected after one strobe
  localparam int NV = 16;
  localparam logic [111:0] VEC [NV] = '{
    112'h59_59_A3_31_12_99_06__00_00_80_01_01_00_00, // R7 R5 R9 new year
    112'h59_59_31_15_03_21_02__00_00_12_16_03_21_03, // R6 11PM -> 12AM next day
    112'h59_59_11_15_03_21_02__00_00_32_15_03_21_02, // R6 11AM -> 12PM
    112'h59_59_32_15_03_21_02__00_00_21_15_03_21_02, // R6 12PM -> 1PM
    112'h59_59_A3_28_02_24_01__00_00_80_29_02_24_02, // R8 leap
    112'h59_59_A3_28_02_23_01__00_00_80_01_03_23_02, // R8 common
    112'h59_59_A3_29_02_00_03__00_00_80_01_03_00_04, // R8 year 00
    112'h59_59_A3_28_02_12_03__00_00_80_29_02_12_04, // R8 year 12
    112'h59_59_A3_28_02_10_03__00_00_80_01_03_10_04, // R8 year 10
    112'h59_59_A3_30_04_05_03__00_00_80_01_05_05_04, // R7 30-day month
    112'h59_59_A3_30_01_05_03__00_00_80_31_01_05_04, // R7 31-day month
    112'h59_59_A3_31_01_05_03__00_00_80_01_02_05_04, // R7 Jan 31
    112'h59_59_A3_30_11_05_03__00_00_80_01_12_05_04, // R7 November
    112'h09_19_85_10_06_07_04__10_19_85_10_06_07_04, // R4 digit carry
    112'h59_19_89_10_06_07_04__00_20_89_10_06_07_04, // R4 minute carry
    112'h59_59_A3_10_06_07_06__00_00_80_11_06_07_00  // R9 weekday wrap
  };

  function automatic logic [55:0] fields();
    return {sec_o, min_o, hour_o, date_o, month_o, year_o, wday_o};
  endfunction

  task automatic check(input string tag, input logic [55:0] act, input logic [55:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [2:0] idx, input logic [7:0] d, input logic allow);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_data = d; wr_allow = allow;
    @(negedge clk);
    wr_en = 1'b0; wr_allow = 1'b1;
  endtask

  task automatic do_tick();
    @(negedge clk);
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values
    check("R1 fields", fields(), 56'h00_00_12_01_01_00_00);
    check("R1 flags", {54'd0, pwr_lost_o, resync_o}, {54'd0, 2'b10});

    // R2 frozen while loss flag set
    repeat (3) do_tick();
    check("R2 frozen", fields(), 56'h00_00_12_01_01_00_00);

    // R3 refused writes
    do_write(3'd0, 8'h30, 1'b0);
    check("R3 no permission", {fields(), 7'd0, pwr_lost_o}, {56'h00_00_12_01_01_00_00, 8'h01});
    do_write(3'd7, 8'h30, 1'b1);
    check("R3 index 7", {fields(), 7'd0, pwr_lost_o}, {56'h00_00_12_01_01_00_00, 8'h01});

    // R2 / R12 first accepted write
    do_write(3'd0, 8'h30, 1'b1);
    check("R2 write clears flag", {8'd0, sec_o, 6'd0, pwr_lost_o, resync_o}, {8'd0, 8'h30, 8'h01});
    @(negedge clk);
    check("R12 pulse one cycle", {55'd0, resync_o}, 56'd0);
    do_tick();
    check("R2 counting", {48'd0, sec_o}, {48'd0, 8'h31});

    // table walk: R4 R5 R6 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      for (int f = 0; f < 7; f++) begin
        do_write(3'(f), VEC[i][111 - 8*f -: 8], 1'b1);
      end
      do_tick();
      check($sformatf("R4-table vector %0d", i), fields(), VEC[i][55:0]);
    end

    // R10 halt and release
    do_write(3'd0, 8'h10, 1'b1);
    @(negedge clk); halt_req = 1'b1;
    @(negedge clk); halt_req = 1'b0;
    repeat (2) do_tick();
    check("R10 halted", {48'd0, sec_o}, {48'd0, 8'h10});
    do_write(3'd1, 8'h22, 1'b1);
    do_tick();
    check("R10 released", {40'd0, sec_o, min_o}, {40'd0, 8'h11, 8'h22});

    // R11 write and strobe in one cycle
    do_write(3'd0, 8'h59, 1'b1);
    @(negedge clk);
    tick_i = 1'b1; wr_en = 1'b1; wr_idx = 3'd1; wr_data = 8'h05;
    @(negedge clk);
    tick_i = 1'b0; wr_en = 1'b0;
    check("R11 write wins", {40'd0, sec_o, min_o}, {40'd0, 8'h59, 8'h05});
    check("R12 pulse", {55'd0, resync_o}, {55'd0, 1'b1});
    do_tick();
    check("R4 after R11", {40'd0, sec_o, min_o}, {40'd0, 8'h00, 8'h06});

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule